// File: doc/BRIEF.md
# Serial Receive FIFO Interrupt Unit

This block sits between the receive shifter of a synchronous serial port and the register bus. Each time the shifter finishes a word it pulses a strobe with the word, and the block stores that word in a small first-in first-out store. The bus side pops words with a read strobe. Read data is driven combinationally while the strobe is high. It is zero when nothing can be popped.

The block raises four interrupt sources:

- overrun, when a word arrives with nowhere to go;
- receive level, when the store is at least half full;
- receive timeout, when words sit unread for too long;
- transmit level, which is passed through from the transmit side.

Each source has a raw status bit and a mask bit. The masked bits are ORed into a single interrupt line. Once an overrun occurs, the port stops storing words until software clears the overrun. A read that lands in the same cycle as the arriving word still makes room for that word.

Status bit positions are fixed: bit 0 is overrun, bit 1 is receive level, bit 2 is timeout and bit 3 is transmit level. The same positions apply to the mask write data and to the masked status output.

Top module: `serrx_irq_unit`

## Requirements
- R1: The store holds eight words, and reads return accepted words in arrival order.
- R2: Status bit 0 (overrun) rises on the clock edge at which a word completes while eight words are held and no read occurs in that cycle. It is not raised earlier.
- R3: While the overrun bit is set, every completing word is discarded. This includes the word that caused the overrun, and it holds even when free slots exist.
- R4: A word that completes in the same cycle as a read of a full store is kept as the newest entry, and no overrun is raised.
- R5: An overrun-clear pulse clears bit 0 on the next edge, and later words are stored again. A word that completes in the same cycle as the clear is still discarded.
- R6: Status bit 2 (timeout) rises on the 32nd bit-period tick, counted while the store is non-empty and with no read since a restart. A read, a timeout-clear pulse or an overrun-clear pulse restarts the count. A read or a timeout-clear also drops bit 2.
- R7: Status bit 1 (receive level) is high exactly while four or more words are held.
- R8: Status bit 3 (transmit level) follows the transmit-level input.
- R9: A mask write loads the four mask bits. The masked status is the raw status ANDed with the masks, and the interrupt line is the OR of the masked bits.
- R10: A read of an empty store returns zero and changes nothing. The word count never goes below zero.
- R11: While reset is held low, the store empties and the raw status, the timeout count and all masks are cleared on each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| wordDone | input | 1 | Shifter finished a word this cycle |
| wordData | input | 16 | Completed word |
| rdStrobe | input | 1 | Pop request from the bus |
| rdData | output | 16 | Popped word, zero when nothing is popped |
| ovrClr | input | 1 | Clear overrun status |
| tmoClr | input | 1 | Clear timeout status and its count |
| bitTick | input | 1 | One pulse per bit period |
| txLevel | input | 1 | Transmit-level request from the transmit side |
| maskWr | input | 1 | Load the mask bits |
| maskData | input | 4 | New mask bits, same order as status |
| rawStatus | output | 4 | Raw source status |
| maskedStatus | output | 4 | Raw status ANDed with masks |
| irq | output | 1 | Combined interrupt |

## Verification
The bench pushes a ninth word into a full store with and without a same-cycle read. A design that compares against the count before the pop would either lose that word or raise a false overrun. It also keeps feeding words while the overrun bit is set and there is space, and clears the overrun in the same cycle as an arriving word. A design that resumes storing too early shows extra words in the read stream. The timeout is stepped tick by tick around the 31st and 32nd ticks, after both a timeout clear and an overrun clear, which exposes off-by-one counting and restart points that were missed. Masks are then toggled against every source, so a wrong bit order shows up on the interrupt line.

// File: rtl/serrx_pkg.sv
package serrx_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
  } fifoCmd_t;

  localparam int SRC_OVR = 0;
  localparam int SRC_LVL = 1;
  localparam int SRC_TMO = 2;
  localparam int SRC_TX  = 3;
  localparam int NUM_SRC = 4;
endpackage

// File: rtl/serrx_datapath.sv
module serrx_datapath
  import serrx_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoCmd_t         cmd,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] headData,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (cmd.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (cmd.push) wrPtr <= nextPtr(wrPtr);
      if (cmd.pop)  rdPtr <= nextPtr(rdPtr);
      case ({cmd.push, cmd.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign headData = mem[rdPtr];
  assign full     = (count == FULL_CNT);
  assign empty    = (count == '0);
endmodule

// File: rtl/serrx_ctrl.sv
module serrx_ctrl
  import serrx_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int LEVEL     = 4,
  parameter int TMO_TICKS = 32,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int TMO_W = $clog2(TMO_TICKS + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wordDone,
  input  logic               rdStrobe,
  input  logic               ovrClr,
  input  logic               tmoClr,
  input  logic               bitTick,
  input  logic               txLevel,
  input  logic               maskWr,
  input  logic [NUM_SRC-1:0] maskData,
  input  logic               full,
  input  logic               empty,
  input  logic [CNT_W-1:0]   count,
  output fifoCmd_t           cmd,
  output logic [NUM_SRC-1:0] rawStatus,
  output logic [NUM_SRC-1:0] maskedStatus,
  output logic               irq
);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_TICKS - 1);
  localparam logic [CNT_W-1:0] LVL_CNT  = CNT_W'(LEVEL);

  logic               ovrQ, tmoQ;
  logic [TMO_W-1:0]   tmoCnt;
  logic [NUM_SRC-1:0] maskQ;
  logic               doPop, doPush, ovrSet, tmoRestart;

  // Read is applied before the incoming word is judged
  assign doPop  = rdStrobe && !empty;
  assign doPush = wordDone && !ovrQ && (!full || doPop);
  assign ovrSet = wordDone && !ovrQ && full && !doPop;

  always_comb begin
    cmd      = '0;
    cmd.push = doPush;
    cmd.pop  = doPop;
  end

  always_ff @(posedge clk) begin
    if (!rstN)       ovrQ <= 1'b0;
    else if (ovrQ)   ovrQ <= !ovrClr;
    else             ovrQ <= ovrSet;
  end

  assign tmoRestart = doPop || tmoClr || ovrClr || empty;

  always_ff @(posedge clk) begin
    if (!rstN)                         tmoCnt <= '0;
    else if (tmoRestart)               tmoCnt <= '0;
    else if (bitTick && !tmoQ)         tmoCnt <= tmoCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   tmoQ <= 1'b0;
    else if (doPop || tmoClr)    tmoQ <= 1'b0;
    else if (!tmoRestart && bitTick && tmoCnt == TMO_LAST)
                                 tmoQ <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)       maskQ <= '0;
    else if (maskWr) maskQ <= maskData;
  end

  always_comb begin
    rawStatus          = '0;
    rawStatus[SRC_OVR] = ovrQ;
    rawStatus[SRC_LVL] = (count >= LVL_CNT);
    rawStatus[SRC_TMO] = tmoQ;
    rawStatus[SRC_TX]  = txLevel;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_mask
    assign maskedStatus[i] = rawStatus[i] & maskQ[i];
  end

  assign irq = |maskedStatus;
endmodule

// File: rtl/serrx_irq_unit.sv
module serrx_irq_unit
  import serrx_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int WIDTH     = 16,
  parameter int LEVEL     = 4,
  parameter int TMO_TICKS = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wordDone,
  input  logic [WIDTH-1:0] wordData,
  input  logic             rdStrobe,
  output logic [WIDTH-1:0] rdData,
  input  logic             ovrClr,
  input  logic             tmoClr,
  input  logic             bitTick,
  input  logic             txLevel,
  input  logic             maskWr,
  input  logic [3:0]       maskData,
  output logic [3:0]       rawStatus,
  output logic [3:0]       maskedStatus,
  output logic             irq
);
  fifoCmd_t         cmd;
  logic [WIDTH-1:0] headData;
  logic [CNT_W-1:0] fifoCount;
  logic             fifoFull, fifoEmpty;

  serrx_ctrl #(.DEPTH(DEPTH), .LEVEL(LEVEL), .TMO_TICKS(TMO_TICKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .wordDone(wordDone), .rdStrobe(rdStrobe),
    .ovrClr(ovrClr), .tmoClr(tmoClr), .bitTick(bitTick), .txLevel(txLevel),
    .maskWr(maskWr), .maskData(maskData), .full(fifoFull), .empty(fifoEmpty),
    .count(fifoCount), .cmd(cmd), .rawStatus(rawStatus),
    .maskedStatus(maskedStatus), .irq(irq)
  );

  serrx_datapath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrData(wordData),
    .headData(headData), .count(fifoCount), .full(fifoFull), .empty(fifoEmpty)
  );

  assign rdData = cmd.pop ? headData : '0;
endmodule

// File: rtl/serrx_irq_chk.sv
module serrx_irq_chk #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             wordDone,
  input logic             rdStrobe,
  input logic [WIDTH-1:0] rdData,
  input logic [3:0]       rawStatus,
  input logic [3:0]       maskedStatus,
  input logic [CNT_W-1:0] fifoCount
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rawStatus[0]) |-> $past(wordDone && fifoCount == FULL_CNT && !rdStrobe)); // R2
  AST_NO_GROW_IN_OVR: assert property (@(posedge clk) disable iff (!rstN)
    rawStatus[0] |=> fifoCount <= $past(fifoCount)); // R3
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= FULL_CNT); // R1
  AST_READ_CLEARS_TMO: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && fifoCount != '0) |=> !rawStatus[2]); // R6
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && fifoCount == '0) |-> rdData == '0); // R10
  AST_MASK_SUBSET: assert property (@(posedge clk) disable iff (!rstN)
    (maskedStatus & ~rawStatus) == 4'b0); // R9
endmodule

bind serrx_irq_unit serrx_irq_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .wordDone(wordDone), .rdStrobe(rdStrobe),
  .rdData(rdData), .rawStatus(rawStatus), .maskedStatus(maskedStatus),
  .fifoCount(fifoCount)
);

// File: tb/sim_serrx_irq_unit.sv
`timescale 1ns/1ps
module sim_serrx_irq_unit;
  logic        clk = 0;
  logic        rstN = 0;
  logic        wordDone = 0;
  logic [15:0] wordData = 0;
  logic        rdStrobe = 0;
  logic [15:0] rdData;
  logic        ovrClr = 0, tmoClr = 0, bitTick = 0, txLevel = 0, maskWr = 0;
  logic [3:0]  maskData = 0;
  logic [3:0]  rawStatus, maskedStatus;
  logic        irq;

  int total = 0, bad = 0;
  logic [15:0] expQ[$];
  logic        ovrModel = 0;
  logic [15:0] seed = 16'h1000;

  always #2.5 clk = ~clk;

  serrx_irq_unit u0 (
    .clk(clk), .rstN(rstN), .wordDone(wordDone), .wordData(wordData),
    .rdStrobe(rdStrobe), .rdData(rdData), .ovrClr(ovrClr), .tmoClr(tmoClr),
    .bitTick(bitTick), .txLevel(txLevel), .maskWr(maskWr), .maskData(maskData),
    .rawStatus(rawStatus), .maskedStatus(maskedStatus), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, updating the scoreboard from the requirements
  task automatic drive(input bit wd, input bit rd, input bit oc, input bit tc,
                       input bit tk, input string req);
    bit          doPop, doPush;
    logic [15:0] expRd;
    seed      = seed + 16'h0101;
    wordDone  = wd; wordData = seed; rdStrobe = rd;
    ovrClr    = oc; tmoClr = tc; bitTick = tk;
    doPop     = rd && expQ.size() > 0;
    doPush    = wd && !ovrModel && (expQ.size() < 8 || doPop);
    expRd     = doPop ? expQ[0] : 16'h0;
    #1;
    if (rd) chk(rdData === expRd, req, rdData, expRd); // monitor compare
    if (doPop) void'(expQ.pop_front());
    if (doPush) expQ.push_back(seed);
    if (ovrModel) ovrModel = !oc;
    else ovrModel = wd && expQ.size() == 8 && !doPush && !doPop;
    @(posedge clk); #1;
    wordDone = 0; rdStrobe = 0; ovrClr = 0; tmoClr = 0; bitTick = 0;
  endtask

  task automatic checkStatus(input string req);
    logic [3:0] e;
    e = {txLevel, 1'b0, expQ.size() >= 4, ovrModel};
    chk(rawStatus[3] === e[3] && rawStatus[1:0] === e[1:0], req, rawStatus, e);
  endtask

  task automatic drain(input string req);
    while (expQ.size() > 0) drive(0, 1, 0, 0, 0, req);
  endtask

  task automatic setMask(input logic [3:0] m);
    maskWr = 1; maskData = m;
    @(posedge clk); #1;
    maskWr = 0;
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11: reset state
    chk(rawStatus === 4'b0 && irq === 1'b0 && maskedStatus === 4'b0, "R11", rawStatus, 0);
    rstN = 1;
    // R10: empty read returns zero and does not underflow
    drive(0, 1, 0, 0, 0, "R10");
    drive(1, 0, 0, 0, 0, "R10");
    drive(0, 1, 0, 0, 0, "R10");
    chk(rawStatus[1] === 1'b0, "R10", rawStatus, 0);
    // R1 / R7: fill, level threshold, ordered drain
    for (int i = 0; i < 8; i++) begin
      drive(1, 0, 0, 0, 0, "R1");
      checkStatus("R7");
    end
    drain("R1");
    checkStatus("R7");
    // R2 / R3: overrun on ninth word, later words dropped even with space
    for (int i = 0; i < 8; i++) drive(1, 0, 0, 0, 0, "R2");
    chk(rawStatus[0] === 1'b0, "R2", rawStatus, 0);
    drive(1, 0, 0, 0, 0, "R2");
    chk(rawStatus[0] === 1'b1, "R2", rawStatus, 1);
    drive(0, 1, 0, 0, 0, "R3");
    drive(1, 0, 0, 0, 0, "R3");
    drive(1, 0, 0, 0, 0, "R3");
    checkStatus("R3");
    drain("R3");
    drive(0, 1, 0, 0, 0, "R3");
    // R5: clear with a same-cycle word drops that word, then accepts again
    drive(1, 0, 1, 0, 0, "R5");
    chk(rawStatus[0] === 1'b0, "R5", rawStatus, 0);
    drive(1, 0, 0, 0, 0, "R5");
    drive(1, 0, 0, 0, 0, "R5");
    checkStatus("R5");
    drain("R5");
    // R4: read and completion together on a full store
    for (int i = 0; i < 8; i++) drive(1, 0, 0, 0, 0, "R4");
    drive(1, 1, 0, 0, 0, "R4");
    chk(rawStatus[0] === 1'b0, "R4", rawStatus, 0);
    drain("R4");
    // R6: timeout after 32 ticks
    drive(1, 0, 0, 0, 0, "R6");
    for (int i = 0; i < 31; i++) drive(0, 0, 0, 0, 1, "R6");
    chk(rawStatus[2] === 1'b0, "R6", rawStatus, 0);
    drive(0, 0, 0, 0, 1, "R6");
    chk(rawStatus[2] === 1'b1, "R6", rawStatus, 4);
    drive(0, 0, 0, 1, 0, "R6");
    chk(rawStatus[2] === 1'b0, "R6", rawStatus, 0);
    for (int i = 0; i < 31; i++) drive(0, 0, 0, 0, 1, "R6");
    chk(rawStatus[2] === 1'b0, "R6", rawStatus, 0);
    drive(0, 0, 0, 0, 1, "R6");
    chk(rawStatus[2] === 1'b1, "R6", rawStatus, 4);
    drain("R6");
    chk(rawStatus[2] === 1'b0, "R6", rawStatus, 0);
    drive(1, 0, 0, 0, 0, "R6");
    for (int i = 0; i < 20; i++) drive(0, 0, 0, 0, 1, "R6");
    drive(0, 0, 1, 0, 0, "R6");
    for (int i = 0; i < 31; i++) drive(0, 0, 0, 0, 1, "R6");
    chk(rawStatus[2] === 1'b0, "R6", rawStatus, 0);
    drive(0, 0, 0, 0, 1, "R6");
    chk(rawStatus[2] === 1'b1, "R6", rawStatus, 4);
    drain("R6");
    // R8 / R9: transmit level and masks
    txLevel = 1; #1;
    chk(rawStatus[3] === 1'b1 && irq === 1'b0, "R8", rawStatus, 8);
    setMask(4'b1000);
    chk(irq === 1'b1 && maskedStatus === 4'b1000, "R9", maskedStatus, 8);
    setMask(4'b0111);
    chk(irq === 1'b0 && maskedStatus === 4'b0000, "R9", maskedStatus, 0);
    txLevel = 0;
    for (int i = 0; i < 4; i++) drive(1, 0, 0, 0, 0, "R9");
    chk(irq === 1'b1 && maskedStatus === 4'b0010, "R9", maskedStatus, 2);
    drain("R9");
    chk(irq === 1'b0, "R9", irq, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule